// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer with Cause/Mask Interrupt

This block holds three 32-bit down-counters behind a small synchronous register port. Channels 0 and 1 are general-purpose timers and channel 2 is a watchdog-style counter. Its expiry only raises an interrupt cause; it never resets the system. Each channel has a live count register and a reload register. A shared control register carries one enable bit and one auto-reload bit per channel. With auto-reload clear, a channel runs once and then parks at zero (one-shot). With auto-reload set, it refills from its reload register on every expiry (periodic, or free-running when the reload value is all ones).

Each expiry sets a bit in a cause register. A mask register selects which cause bits drive the single interrupt output. Software acknowledges an event by writing the cause register with zeros in the bits to clear and ones elsewhere. This lets several handlers share the register without read-modify-write races.

The register port has no valid/ready handshake. A write is accepted on every clock where `bus_wr` is high, so there is no back-pressure. Reads are combinational from `bus_addr`.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the control, cause and mask registers, all count registers and all reload registers read 0, and `irq` is low.
- R2: While its enable bit is set, a channel's count drops by exactly one on every clock. While the enable bit is clear, the count holds.
- R3: Control bit 2x enables channel x and control bit 2x+1 enables its auto-reload. For the watchdog channel (x=2) these are bits 4 and 5. Control reads back in bits [5:0].
- R4: Suppose a count N (1 to 0xFFFFFFFE) is written while the channel is enabled. Its cause bit then reads 1 exactly N clocks after the writing edge, and reads 0 one clock earlier.
- R5: One-shot (auto-reload clear): after expiry the count reads 0 and stays 0, and no further cause is raised until software writes the count again.
- R6: Periodic (auto-reload set): on expiry the count takes the reload value on the same edge, so with reload value R the cause is raised every R clocks.
- R7: With auto-reload set and reload value 0xFFFFFFFF, the count wraps from 1 straight to 0xFFFFFFFF. 0xFFFFFFFF minus the count then gives the clocks elapsed since it was loaded with 0xFFFFFFFF.
- R8: The cause bit for channel x is bit x+1 (timer 0 bit 1, timer 1 bit 2, watchdog bit 3). Cause bit 0 and bits above 3 always read 0.
- R9: A write to the cause register clears each cause bit whose write data is 0 and leaves each bit whose write data is 1 unchanged. Writing 1 never sets a bit.
- R10: If an expiry and a cause-register write that clears the same bit land on the same edge, the bit ends up set.
- R11: `irq` is high exactly when some cause bit is 1 and the mask bit at the same position is 1. The mask uses the cause bit positions.
- R12: Word addresses: 0 control, 1 cause, 2 mask, then channel x count at 3+2x and reload at 4+2x (addresses 3 to 8). A software write to a count takes priority over counting on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write is accepted on this clock |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked OR of the cause bits |

## Verification
The hardest case to reach is an expiry that falls on the same edge as a software clear of its cause bit. Exact tick counts (R4, R6) need the same edge-accurate placement. Every bench write task takes exactly one clock edge and every idle step takes one edge. This lets the bench load a count N and issue the cause-clear write on the Nth edge after it, which puts the collision on a known cycle. The same accounting samples the cause bit one edge before and on the expiry edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW  = 32;
  localparam int AW  = 4;
  localparam int NCH = 3;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_CAUSE = 1;
  localparam int ADR_MASK  = 2;
  localparam int ADR_CH0   = 3;

  function automatic int cnt_addr(input int ch);
    return ADR_CH0 + 2 * ch;
  endfunction

  function automatic int rld_addr(input int ch);
    return ADR_CH0 + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rl_en,
  input  logic          cnt_wr,
  input  logic          rld_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] rld,
  output logic          expire
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ZERO = '0;

  assign expire = en && !cnt_wr && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld <= ZERO;
    end else if (rld_wr) begin
      rld <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= ZERO;
    end else if (cnt_wr) begin
      cnt <= wdata;
    end else if (en) begin
      if (cnt == ONE) begin
        cnt <= rl_en ? rld : ZERO;
      end else if (cnt == ZERO) begin
        if (rl_en) cnt <= rld;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_wr && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt));

  assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rl_en && !cnt_wr && cnt <= ONE) |=> (cnt == ZERO));

  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rl_en && !rld_wr) |=> (cnt == rld));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic           cause_wr,
  input  logic           mask_wr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] cause,
  output logic [NCH-1:0] mask,
  output logic           irq
);
  logic [NCH-1:0] cause_kept;

  assign cause_kept = cause_wr ? (cause & wbits) : cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= cause_kept | set;
      if (mask_wr) mask <= wbits;
    end
  end

  assign irq = |(cause & mask);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((cause & $past(set)) == $past(set)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((cause & ~$past(wbits) & ~$past(set)) == '0));

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((cause & $past(cause & wbits)) == $past(cause & wbits)));

  assert_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int CW = 2 * NCH;

  logic [CW-1:0]  ctrl;
  logic [NCH-1:0] expire;
  logic [NCH-1:0] cause;
  logic [NCH-1:0] mask;
  logic [DW-1:0]  cnt [NCH];
  logic [DW-1:0]  rld [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (bus_wr && bus_addr == AW'(ADR_CTRL)) begin
      ctrl <= bus_wdata[CW-1:0];
    end
  end

  for (genvar x = 0; x < NCH; x++) begin : g_ch
    tmr_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl[2*x]),
      .rl_en  (ctrl[2*x+1]),
      .cnt_wr (bus_wr && bus_addr == AW'(cnt_addr(x))),
      .rld_wr (bus_wr && bus_addr == AW'(rld_addr(x))),
      .wdata  (bus_wdata),
      .cnt    (cnt[x]),
      .rld    (rld[x]),
      .expire (expire[x])
    );
  end

  tmr_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (expire),
    .cause_wr (bus_wr && bus_addr == AW'(ADR_CAUSE)),
    .mask_wr  (bus_wr && bus_addr == AW'(ADR_MASK)),
    .wbits    (bus_wdata[NCH:1]),
    .cause    (cause),
    .mask     (mask),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADR_CTRL))  bus_rdata = DW'(ctrl);
    if (bus_addr == AW'(ADR_CAUSE)) bus_rdata = DW'({cause, 1'b0});
    if (bus_addr == AW'(ADR_MASK))  bus_rdata = DW'({mask, 1'b0});
    for (int x = 0; x < NCH; x++) begin
      if (bus_addr == AW'(cnt_addr(x))) bus_rdata = cnt[x];
      if (bus_addr == AW'(rld_addr(x))) bus_rdata = rld[x];
    end
  end

  assert_cause_b0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADR_CAUSE)) |-> (bus_rdata[0] == 1'b0));

  assert_ctrl_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(ADR_CTRL)) |=> (ctrl == $past(bus_wdata[CW-1:0])));
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] A_CTRL = 0, A_CAUSE = 1, A_MASK = 2;

  always #4 clk = ~clk;

  tmr_unit u_tmr_unit (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                       .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [3:0] a_cnt(input int ch); return 4'(3 + 2 * ch); endfunction
  function automatic logic [3:0] a_rld(input int ch); return 4'(4 + 2 * ch); endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic quiesce();
    wr(A_CTRL, 0); wr(A_CAUSE, 0); wr(A_MASK, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d); chk($sformatf("R1 reg %0d", a), d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int c = 0; c < 3; c++) begin
      wr(a_cnt(c), 32'h1000 + c); wr(a_rld(c), 32'h2000 + c);
    end
    for (int c = 0; c < 3; c++) begin
      rd(a_cnt(c), d); chk("R12 count addr", d, 32'h1000 + c);
      rd(a_rld(c), d); chk("R12 reload addr", d, 32'h2000 + c);
    end
    wr(A_CTRL, 32'hFFFF_FFC0); rd(A_CTRL, d); chk("R3 ctrl width", d, 0);
  endtask

  task automatic t_decrement();
    logic [31:0] d;
    quiesce();
    wr(A_CTRL, 32'h4);          // R3: bit 2 enables channel 1
    wr(a_cnt(1), 100);
    idle(10);
    rd(a_cnt(1), d); chk("R2 down 10", d, 90);
    rd(a_cnt(0), d); chk("R3 ch0 idle", d, 32'h1000);
    wr(A_CTRL, 0);
    idle(5);
    rd(a_cnt(1), d); chk("R2 hold when off", d, 89);
  endtask

  task automatic t_exact(input int n);
    logic [31:0] d;
    quiesce();
    wr(A_CTRL, 32'h1);
    wr(a_cnt(0), n);
    if (n > 1) begin
      idle(n - 1);
      rd(A_CAUSE, d); chk($sformatf("R4 early N=%0d", n), d, 0);
    end
    idle(1);
    rd(A_CAUSE, d); chk($sformatf("R4 expire N=%0d", n), d, 32'h2);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    t_exact(2);
    idle(5);
    rd(a_cnt(0), d); chk("R5 parked", d, 0);
    wr(A_CAUSE, 0);
    idle(4);
    rd(A_CAUSE, d); chk("R5 no re-fire", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    quiesce();
    wr(a_rld(0), 4); wr(a_cnt(0), 4); wr(A_CTRL, 32'h3);
    idle(4);
    rd(A_CAUSE, d); chk("R6 first expiry", d, 32'h2);
    rd(a_cnt(0), d); chk("R6 refilled", d, 4);
    wr(A_CAUSE, ~32'h2);
    idle(2);
    rd(A_CAUSE, d); chk("R6 quiet between", d, 0);
    idle(1);
    rd(A_CAUSE, d); chk("R6 second expiry", d, 32'h2);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    quiesce();
    wr(a_rld(1), 32'hFFFF_FFFF); wr(a_cnt(1), 32'hFFFF_FFFF); wr(A_CTRL, 32'hC);
    idle(3);
    rd(a_cnt(1), d); chk("R7 elapsed", 32'hFFFF_FFFF - d, 3);
    wr(a_cnt(1), 2);
    idle(2);
    rd(a_cnt(1), d); chk("R7 wrap", d, 32'hFFFF_FFFF);
    rd(A_CAUSE, d); chk("R8 timer1 bit2", d, 32'h4);
  endtask

  task automatic t_watchdog_irq();
    logic [31:0] d;
    quiesce();
    wr(A_MASK, 32'h8);
    wr(A_CTRL, 32'h10);         // R3: bit 4 enables watchdog
    wr(a_cnt(2), 3);
    idle(2);
    chk("R11 irq before", {31'b0, irq}, 0);
    idle(1);
    rd(A_CAUSE, d); chk("R8 watchdog bit3", d, 32'h8);
    chk("R11 irq on", {31'b0, irq}, 1);
    wr(A_MASK, 32'h2);
    chk("R11 other mask", {31'b0, irq}, 0);
    rd(A_MASK, d); chk("R11 mask readback", d, 32'h2);
  endtask

  task automatic t_cause_write();
    logic [31:0] d;
    quiesce();
    wr(A_CTRL, 32'h11);
    wr(a_cnt(0), 1); wr(A_CTRL, 32'h11);
    wr(a_cnt(2), 1); wr(A_CTRL, 32'h11);
    rd(A_CAUSE, d); chk("R9 setup", d, 32'hA);
    wr(A_CAUSE, ~32'h8);
    rd(A_CAUSE, d); chk("R9 clear zeros only", d, 32'h2);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, d); chk("R8 ones no set", d, 32'h2);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    quiesce();
    wr(A_CTRL, 32'h1);
    wr(a_cnt(0), 3);
    idle(2);
    wr(A_CAUSE, 0);             // lands on the expiry edge
    rd(A_CAUSE, d); chk("R10 set wins", d, 32'h2);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1;
        t_reset(); t_map(); t_decrement();
        t_exact(1); t_exact(5); t_exact(37);
        t_oneshot(); t_periodic(); t_freerun();
        t_watchdog_irq(); t_cause_write(); t_collision();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule